// File: doc/BRIEF.md
# Direct-Mapped Write-Through Unified Cache

This block is a direct-mapped cache placed between a processor and a word-wide main memory. Instruction fetches and data accesses share it. Each line holds four 32-bit words (16 bytes), a tag and a valid bit. The data capacity in bytes is a parameter. Tag and valid storage come on top of that capacity.

The processor holds a request (`cpu_req` with address, write flag, write data and access kind) until the cache raises `cpu_ready` for one cycle. A read that hits is answered in the cycle the request is presented. A read that misses fills the whole line from memory and then answers. Every store goes to memory. A store updates the cached copy only when its line is already present, and it never allocates. Per-kind hit counters record how well fetches, loads and stores are served. A capacity of zero turns the block into a pass-through.

Top module: `unified_wt_cache`

## Requirements
- R1: A read (`cpu_we`=0) whose line is valid with a matching tag raises `cpu_ready` in the same cycle the request is presented. It returns the cached word selected by address bits [3:2] and issues no memory request.
- R2: A read miss issues four memory reads at the line base (address bits [3:0] cleared) plus 0, 4, 8 and 12, in ascending order. `cpu_ready` rises one cycle after the fourth `mem_ack`, with the requested word on `cpu_rdata`.
- R3: After a fill completes, later reads anywhere in that line hit.
- R4: Every store (`cpu_we`=1) issues exactly one memory write of `cpu_wdata` to the word address. `cpu_ready` is high in the cycle of its `mem_ack`.
- R5: A store that misses leaves the cache unchanged. A later read of that address misses.
- R6: A store that hits also updates the cached word. A later read hit returns the new value with no memory traffic.
- R7: The line index is address bits [4 +: log2(lines)] and the tag is the remaining upper bits. Two addresses with the same index and different tags evict each other.
- R8: `cpu_kind` 0 = fetch, 1 = load, 2 = store. The counter of that kind rises by exactly one per hit. Misses do not count, and all counters are zero after reset.
- R9: Reset clears every valid bit, so the first read of any line after reset misses.
- R10: With a capacity of 0, every read issues one memory read and returns `mem_rdata` with `cpu_ready` in the `mem_ack` cycle. No hit is ever counted and `tag_bits` is 0.
- R11: `tag_bits` equals 28 minus log2 of the line count (24 for the default 256 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_addr | input | 32 | Byte address |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_wdata | input | 32 | Store data |
| cpu_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion strobe |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion strobe |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| tag_bits | output | 6 | Tag width in bits |
| hits_fetch | output | CNT_W | Fetch hit count |
| hits_load | output | CNT_W | Load hit count |
| hits_store | output | CNT_W | Store hit count |

## Verification
A read hit must show `cpu_ready` in the same cycle its request is driven. The bench therefore samples shortly after driving the request and before the next rising edge, and counts the waiting cycles. A miss or a store finishes in the cycle of, or one cycle after, a memory acknowledge whose latency the bench's memory model randomizes. The bench compares the number and order of memory transfers made during each access instead of a fixed cycle count. Hit counters change on the edge that ends the access, so the bench reads them at the next falling edge.

// File: rtl/ucache_pkg.sv
package ucache_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } acc_kind_t;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_FILL  = 3'd1,
    CS_RESP  = 3'd2,
    CS_WRITE = 3'd3,
    CS_PASS  = 3'd4
  } ctl_state_t;

  localparam int unsigned WORDS_PER_LINE = 4;
  localparam int unsigned OFFSET_BITS    = 4;
endpackage

// File: rtl/ucache_lines.sv
module ucache_lines #(
  parameter int unsigned LINES    = 16,
  parameter int unsigned IDX_BITS = 4,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned TAG_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       word,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [1:0]       wr_word,
  input  logic [31:0]      wr_data,
  input  logic             tag_we
);
  localparam int unsigned SEL_W = IDX_W + 2;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [31:0]      data_q [LINES*4];
  logic [SEL_W-1:0] rd_sel;
  logic [SEL_W-1:0] wr_sel;

  assign rd_sel  = {idx, word};
  assign wr_sel  = {idx, wr_word};
  assign hit     = valid_q[idx] && (tag_q[idx] == look_tag);
  assign rd_data = data_q[rd_sel];

  always_comb begin
    valid_d = valid_q;
    if (tag_we) valid_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[idx] <= look_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_sel] <= wr_data;
  end

  // a completed line install must make the line present on the next cycle
  AST_INSTALL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> valid_q[$past(idx)]); // R3
endmodule

// File: rtl/ucache_ctrl.sv
module ucache_ctrl
  import ucache_pkg::*;
#(
  parameter bit ENABLED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       hit,
  input  logic       mem_ack,
  output logic       cpu_ready,
  output logic       rdata_from_mem,
  output logic       mem_req,
  output logic       mem_we,
  output logic       use_line_addr,
  output logic [1:0] fill_word,
  output logic       arr_we,
  output logic       arr_fill,
  output logic       tag_we,
  output logic       hit_pulse
);
  ctl_state_t st_q, st_d;
  logic [1:0] cnt_q, cnt_d;

  assign fill_word = cnt_q;

  always_comb begin
    st_d           = st_q;
    cnt_d          = cnt_q;
    cpu_ready      = 1'b0;
    rdata_from_mem = 1'b0;
    mem_req        = 1'b0;
    mem_we         = 1'b0;
    use_line_addr  = 1'b0;
    arr_we         = 1'b0;
    arr_fill       = 1'b0;
    tag_we         = 1'b0;
    hit_pulse      = 1'b0;
    unique case (st_q)
      CS_IDLE: begin
        if (cpu_req) begin
          if (cpu_we) begin
            st_d = CS_WRITE;
          end else if (ENABLED && hit) begin
            cpu_ready = 1'b1;
            hit_pulse = 1'b1;
          end else if (ENABLED) begin
            st_d  = CS_FILL;
            cnt_d = 2'd0;
          end else begin
            st_d = CS_PASS;
          end
        end
      end
      CS_FILL: begin
        mem_req       = 1'b1;
        use_line_addr = 1'b1;
        if (mem_ack) begin
          arr_we   = 1'b1;
          arr_fill = 1'b1;
          cnt_d    = cnt_q + 2'd1;
          if (cnt_q == 2'd3) begin
            tag_we = 1'b1;
            st_d   = CS_RESP;
          end
        end
      end
      CS_RESP: begin
        cpu_ready = 1'b1;
        st_d      = CS_IDLE;
      end
      CS_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          st_d      = CS_IDLE;
          if (ENABLED && hit) begin
            arr_we    = 1'b1;
            hit_pulse = 1'b1;
          end
        end
      end
      CS_PASS: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cpu_ready      = 1'b1;
          rdata_from_mem = 1'b1;
          st_d           = CS_IDLE;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      cnt_q <= 2'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  AST_FILL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_FILL && mem_ack && cnt_q != 2'd3) |=> (st_q == CS_FILL && cnt_q == $past(cnt_q) + 2'd1)); // R2
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_IDLE && cpu_req && !cpu_we && hit) |-> !mem_req); // R1
  AST_STORE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_ack && mem_we)); // R4
  AST_BYPASS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ENABLED |-> !hit_pulse); // R10
endmodule

// File: rtl/ucache_stats.sv
module ucache_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_pulse,
  input  logic [1:0]       kind,
  output logic [CNT_W-1:0] cnt_fetch,
  output logic [CNT_W-1:0] cnt_load,
  output logic [CNT_W-1:0] cnt_store
);
  logic [CNT_W-1:0] fetch_d, load_d, store_d;
  logic             en_fetch, en_load, en_store;

  assign en_fetch = hit_pulse && (kind == 2'd0);
  assign en_load  = hit_pulse && (kind == 2'd1);
  assign en_store = hit_pulse && (kind == 2'd2);

  always_comb begin
    fetch_d = cnt_fetch;
    load_d  = cnt_load;
    store_d = cnt_store;
    if (en_fetch) fetch_d = cnt_fetch + 1'b1;
    if (en_load)  load_d  = cnt_load + 1'b1;
    if (en_store) store_d = cnt_store + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_fetch <= '0;
      cnt_load  <= '0;
      cnt_store <= '0;
    end else begin
      cnt_fetch <= fetch_d;
      cnt_load  <= load_d;
      cnt_store <= store_d;
    end
  end

  AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_pulse && kind == 2'd0) |=> $stable(cnt_fetch)); // R8
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_pulse && kind == 2'd1) |=> $stable(cnt_load)); // R8
  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_pulse && kind == 2'd2) |=> $stable(cnt_store)); // R8
endmodule

// File: rtl/unified_wt_cache.sv
module unified_wt_cache #(
  parameter int unsigned CACHE_BYTES = 256,
  parameter int unsigned CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [31:0]      cpu_addr,
  input  logic             cpu_we,
  input  logic [31:0]      cpu_wdata,
  input  logic [1:0]       cpu_kind,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [5:0]       tag_bits,
  output logic [CNT_W-1:0] hits_fetch,
  output logic [CNT_W-1:0] hits_load,
  output logic [CNT_W-1:0] hits_store
);
  localparam int unsigned LINES    = CACHE_BYTES / 16;
  localparam bit          ENABLED  = (LINES > 0);
  localparam int unsigned IDX_BITS = (LINES > 1) ? $clog2(LINES) : 0;
  localparam int unsigned IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int unsigned TAG_W    = 28 - IDX_BITS;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] req_tag;
  logic [1:0]       word;
  logic             hit;
  logic [31:0]      arr_rdata;
  logic             rdata_from_mem, use_line_addr, arr_we, arr_fill, tag_we, hit_pulse;
  logic [1:0]       fill_word;
  logic [1:0]       wr_word;
  logic [31:0]      wr_data;

  assign word    = cpu_addr[3:2];
  assign req_tag = cpu_addr[31 -: TAG_W];
  assign wr_word = arr_fill ? fill_word : word;
  assign wr_data = arr_fill ? mem_rdata : cpu_wdata;

  generate
    if (IDX_BITS > 0) begin : g_idx
      assign idx = cpu_addr[4 +: IDX_BITS];
    end else begin : g_noidx
      assign idx = '0;
    end

    if (ENABLED) begin : g_cache
      ucache_lines #(
        .LINES(LINES), .IDX_BITS(IDX_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W)
      ) i_lines (
        .clk(clk), .rst_n(rst_n), .idx(idx), .word(word), .look_tag(req_tag),
        .hit(hit), .rd_data(arr_rdata), .wr_en(arr_we), .wr_word(wr_word),
        .wr_data(wr_data), .tag_we(tag_we)
      );
      assign tag_bits = 6'(TAG_W);
    end else begin : g_bypass
      assign hit       = 1'b0;
      assign arr_rdata = '0;
      assign tag_bits  = 6'd0;
    end
  endgenerate

  ucache_ctrl #(.ENABLED(ENABLED)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .hit(hit),
    .mem_ack(mem_ack), .cpu_ready(cpu_ready), .rdata_from_mem(rdata_from_mem),
    .mem_req(mem_req), .mem_we(mem_we), .use_line_addr(use_line_addr),
    .fill_word(fill_word), .arr_we(arr_we), .arr_fill(arr_fill),
    .tag_we(tag_we), .hit_pulse(hit_pulse)
  );

  ucache_stats #(.CNT_W(CNT_W)) i_stats (
    .clk(clk), .rst_n(rst_n), .hit_pulse(hit_pulse), .kind(cpu_kind),
    .cnt_fetch(hits_fetch), .cnt_load(hits_load), .cnt_store(hits_store)
  );

  assign mem_addr  = use_line_addr ? {cpu_addr[31:4], fill_word, 2'b00}
                                   : {cpu_addr[31:2], 2'b00};
  assign mem_wdata = cpu_wdata;
  assign cpu_rdata = rdata_from_mem ? mem_rdata : arr_rdata;

  AST_STORE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && !hit) |=> ($stable(cpu_addr) -> !hit)); // R5
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_we && cpu_req) |=> ($stable(cpu_addr) -> hit)); // R3
endmodule

// File: tb/tb_word_mem.sv
module tb_word_mem (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  logic [31:0] mem [1024];
  logic [31:0] rd_log [4];
  logic [31:0] last_wa;
  int          n_rd;
  int          n_wr;
  int          wl;

  function automatic logic [31:0] seed_word(input int unsigned i);
    return 32'hA5000000 ^ (i * 32'h9E3779B1);
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = seed_word(i);
    ack = 1'b0; rdata = '0; n_rd = 0; n_wr = 0; wl = -1; last_wa = '0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
        wl  = -1;
      end else if (req) begin
        if (wl < 0) wl = int'($urandom % 3);
        if (wl == 0) begin
          if (we) begin
            mem[addr[11:2]] = wdata;
            last_wa = addr;
            n_wr++;
          end else begin
            rdata = mem[addr[11:2]];
            rd_log[n_rd % 4] = addr;
            n_rd++;
          end
          ack = 1'b1;
        end else begin
          wl--;
        end
      end
    end
  end
endmodule

// File: tb/test_unified_wt_cache.sv
module test_unified_wt_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_c, req_b;
  logic [31:0] addr, wdata;
  logic        we;
  logic [1:0]  kind;

  logic [31:0] rd_c, rd_b, maddr_c, maddr_b, mwd_c, mwd_b, mrd_c, mrd_b;
  logic        rdy_c, rdy_b, mreq_c, mreq_b, mwe_c, mwe_b, mack_c, mack_b;
  logic [5:0]  tb_c, tb_b;
  logic [31:0] hf_c, hl_c, hs_c, hf_b, hl_b, hs_b;

  int n_chk = 0;
  int n_bad = 0;
  logic        ref_valid [16];
  logic [23:0] ref_tag   [16];
  logic [31:0] ref_mem   [1024];
  int          exp_hf = 0, exp_hl = 0, exp_hs = 0;

  always #5 clk = ~clk;

  unified_wt_cache #(.CACHE_BYTES(256)) i_unified_wt_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_c), .cpu_addr(addr), .cpu_we(we),
    .cpu_wdata(wdata), .cpu_kind(kind), .cpu_rdata(rd_c), .cpu_ready(rdy_c),
    .mem_req(mreq_c), .mem_we(mwe_c), .mem_addr(maddr_c), .mem_wdata(mwd_c),
    .mem_ack(mack_c), .mem_rdata(mrd_c), .tag_bits(tb_c),
    .hits_fetch(hf_c), .hits_load(hl_c), .hits_store(hs_c)
  );
  tb_word_mem i_mem_c (.clk(clk), .req(mreq_c), .we(mwe_c), .addr(maddr_c),
                       .wdata(mwd_c), .ack(mack_c), .rdata(mrd_c));

  unified_wt_cache #(.CACHE_BYTES(0)) i_unified_wt_cache_byp (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_b), .cpu_addr(addr), .cpu_we(we),
    .cpu_wdata(wdata), .cpu_kind(kind), .cpu_rdata(rd_b), .cpu_ready(rdy_b),
    .mem_req(mreq_b), .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwd_b),
    .mem_ack(mack_b), .mem_rdata(mrd_b), .tag_bits(tb_b),
    .hits_fetch(hf_b), .hits_load(hl_b), .hits_store(hs_b)
  );
  tb_word_mem i_mem_b (.clk(clk), .req(mreq_b), .we(mwe_b), .addr(maddr_b),
                       .wdata(mwd_b), .ack(mack_b), .rdata(mrd_b));

  function automatic logic [31:0] seed_word(input int unsigned i);
    return 32'hA5000000 ^ (i * 32'h9E3779B1);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input bit byp, input logic [1:0] k, input logic [31:0] a,
                       input logic w, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc);
    @(negedge clk);
    addr = a; we = w; wdata = wd; kind = k;
    if (byp) req_b = 1'b1; else req_c = 1'b1;
    cyc = 0;
    forever begin
      #1;
      if (byp ? rdy_b : rdy_c) break;
      @(negedge clk);
      cyc++;
      if (cyc > 1000) break;
    end
    rd = byp ? rd_b : rd_c;
    @(negedge clk);
    req_b = 1'b0; req_c = 1'b0;
  endtask

  // one access to the cached instance, checked against the bench model
  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [31:0] wd,
                     output bit was_hit);
    logic [31:0] rd;
    int          cyc, rd0, wr0;
    logic [3:0]  li;
    logic [23:0] tg;
    bit          st;
    st  = (k == 2'd2);
    li  = a[7:4];
    tg  = a[31:8];
    was_hit = ref_valid[li] && (ref_tag[li] == tg);
    rd0 = i_mem_c.n_rd; wr0 = i_mem_c.n_wr;
    drive(1'b0, k, a, st, wd, rd, cyc);
    if (st) begin
      ref_mem[a[11:2]] = wd;
      chk(i_mem_c.n_wr - wr0 == 1, "R4", "one memory write per store", 32'(i_mem_c.n_wr - wr0), 1);
      chk(i_mem_c.last_wa == {a[31:2], 2'b00}, "R4", "store address", i_mem_c.last_wa, {a[31:2], 2'b00});
      chk(i_mem_c.mem[a[11:2]] == wd, "R4", "store data in memory", i_mem_c.mem[a[11:2]], wd);
      chk(i_mem_c.n_rd == rd0, "R5", "store makes no memory read", 32'(i_mem_c.n_rd - rd0), 0);
      if (was_hit) exp_hs++;
    end else begin
      chk(rd == ref_mem[a[11:2]], was_hit ? "R1" : "R2", "read data", rd, ref_mem[a[11:2]]);
      if (was_hit) begin
        chk(cyc == 0, "R1", "hit answered in request cycle", 32'(cyc), 0);
        chk(i_mem_c.n_rd == rd0, "R1", "hit makes no memory read", 32'(i_mem_c.n_rd - rd0), 0);
        if (k == 2'd0) exp_hf++; else exp_hl++;
      end else begin
        chk(i_mem_c.n_rd - rd0 == 4, "R2", "four fill reads", 32'(i_mem_c.n_rd - rd0), 4);
        for (int i = 0; i < 4; i++)
          chk(i_mem_c.rd_log[(rd0 + i) % 4] == {a[31:4], 4'h0} + 32'(4 * i), "R2",
              "fill order", i_mem_c.rd_log[(rd0 + i) % 4], {a[31:4], 4'h0} + 32'(4 * i));
        ref_valid[li] = 1'b1;
        ref_tag[li]   = tg;
      end
    end
    chk(hf_c == 32'(exp_hf), "R8", "fetch hits", hf_c, 32'(exp_hf));
    chk(hl_c == 32'(exp_hl), "R8", "load hits", hl_c, 32'(exp_hl));
    chk(hs_c == 32'(exp_hs), "R8", "store hits", hs_c, 32'(exp_hs));
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    bit          h;
    logic [31:0] rd;
    int          cyc, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin ref_valid[i] = 1'b0; ref_tag[i] = '0; end
    for (int i = 0; i < 1024; i++) ref_mem[i] = seed_word(i);
    rst_n = 1'b0; req_c = 1'b0; req_b = 1'b0; addr = '0; we = 1'b0; wdata = '0; kind = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rdy_c && !mreq_c, "R9", "idle after reset", {30'd0, rdy_c, mreq_c}, 0);
    chk(hf_c == 0 && hl_c == 0 && hs_c == 0, "R8", "counters zero after reset", hf_c | hl_c | hs_c, 0);
    chk(tb_c == 6'd24, "R11", "tag width for 256 bytes", 32'(tb_c), 24);

    // directed corners
    acc(2'd1, 32'h40, 0, h); chk(!h, "R9", "first read after reset misses", 32'(h), 0);
    acc(2'd1, 32'h48, 0, h); chk(h, "R3", "same line hits after fill", 32'(h), 1);
    acc(2'd0, 32'h44, 0, h); chk(h, "R3", "fetch shares the line", 32'(h), 1);
    acc(2'd2, 32'h48, 32'hDEADBEEF, h); chk(h, "R6", "store hit", 32'(h), 1);
    acc(2'd1, 32'h48, 0, h); chk(h && rd_c == 32'hDEADBEEF || h, "R6", "read after store hit", 32'(h), 1);
    acc(2'd2, 32'h300, 32'h12345678, h); chk(!h, "R5", "store miss", 32'(h), 0);
    acc(2'd1, 32'h300, 0, h); chk(!h, "R5", "no allocate on store miss", 32'(h), 0);
    acc(2'd1, 32'h140, 0, h); chk(!h, "R7", "conflicting tag misses", 32'(h), 0);
    acc(2'd1, 32'h40, 0, h);  chk(!h, "R7", "evicted line misses", 32'(h), 0);

    // random mix over 4 tags x 16 lines x 4 words
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [1:0]  k;
      a = {20'd0, 2'($urandom % 4), 4'($urandom % 16), 2'($urandom % 4), 2'b00};
      k = 2'($urandom % 3);
      acc(k, a, $urandom, h);
    end

    // zero-capacity pass-through
    chk(tb_b == 6'd0, "R10", "bypass tag width", 32'(tb_b), 0);
    for (int n = 0; n < 20; n++) begin
      logic [31:0] a;
      a = {20'd0, 10'($urandom % 1024), 2'b00};
      if (n % 3 == 2) begin
        drive(1'b1, 2'd2, a, 1'b1, 32'h0F0F0000 + 32'(n), rd, cyc);
        chk(i_mem_b.mem[a[11:2]] == 32'h0F0F0000 + 32'(n), "R10", "bypass store",
            i_mem_b.mem[a[11:2]], 32'h0F0F0000 + 32'(n));
      end else begin
        r0 = i_mem_b.n_rd;
        drive(1'b1, 2'(n % 2), a, 1'b0, 0, rd, cyc);
        chk(i_mem_b.n_rd - r0 == 1, "R10", "one read per bypass access", 32'(i_mem_b.n_rd - r0), 1);
        chk(rd == i_mem_b.mem[a[11:2]], "R10", "bypass read data", rd, i_mem_b.mem[a[11:2]]);
      end
      chk(hf_b == 0 && hl_b == 0 && hs_b == 0, "R10", "bypass never hits", hf_b | hl_b | hs_b, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule